// File: doc/BRIEF.md
# Synchronized 8-bit Timer/Counter

This block is the eight-bit up-counter of a small processor core. It advances either once per instruction cycle or on a chosen edge of an external input pin. When the shared prescaler is assigned to it, it advances on the prescaler's output instead. The pin is brought into the clock domain through a two-flop synchronizer, and its polarity is set by an edge-select bit. Whatever tick drives the count is looked at only on the second and fourth quarter-phase strobes of each instruction cycle. The count itself moves only on the fourth strobe.

The CPU reads the count directly and loads it through a write strobe. A load freezes the count for the next two instruction cycles. When the prescaler belongs to this timer, a load also sends a one-cycle clear pulse to the prescaler. A wrap from all-ones to zero sets a sticky flag. Software clears the flag, and the flag is gated with an enable to form the interrupt request. In sleep the count is frozen, so the block can raise no flag there.

The block also drives the raw source toward the external prescaler: the instruction-cycle strobe, or the pin after polarity selection.

Top module: `sync_timer8`

## Requirements
- R1: With `src_ext`=0 and `use_ps`=0, the count rises by exactly one on every clock edge at which `ph_q4` is high. The count never changes at an edge where `ph_q4` is low, unless a write occurs at that edge.
- R2: With `src_ext`=1 and `use_ps`=0, the count rises by one per rising edge of `ext_pin` when `edge_fall`=0, and per falling edge when `edge_fall`=1. Changing `edge_fall` at a moment when it turns the effective level from high to low adds nothing.
- R3: `wr_en` loads `wr_data` at that edge. The next two `ph_q4` edges leave the value unchanged, and the third one may increment it.
- R4: An increment from 8'hFF to 8'h00 sets `ovf_flag`. The flag stays set until a `flag_clr` edge. If a clear and a wrap land on the same edge, the flag stays set.
- R5: `irq` is high exactly when `ovf_flag` and `irq_en` are both high. With `irq_en` low, a wrap still sets `ovf_flag`.
- R6: The selected tick is sampled only at `ph_q2` and `ph_q4` edges. An effective high lasting one clock that straddles neither strobe is lost. A high lasting two clocks is counted once.
- R7: While `sleep` is high the count does not advance and `ovf_flag` is not set.
- R8: A write with `use_ps`=1 makes `ps_clr` high for exactly the following clock cycle. With `use_ps`=0, `ps_clr` stays low.
- R9: With `use_ps`=1, the count rises once per rising edge of `ps_tick`, sampled as in R6, whatever `src_ext` is set to. `pre_src` equals `ph_q4` when `src_ext`=0 and `ext_pin` XOR `edge_fall` when `src_ext`=1.
- R10: After a synchronous reset, the count is 8'h00, `ovf_flag` and `ps_clr` are low, and no hold is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; four periods make one instruction cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| ph_q2 | input | 1 | Second quarter-phase strobe (one clock per instruction cycle) |
| ph_q4 | input | 1 | Fourth quarter-phase strobe (one clock per instruction cycle) |
| ext_pin | input | 1 | Asynchronous external count input |
| src_ext | input | 1 | 0: instruction-cycle source, 1: external pin |
| edge_fall | input | 1 | 0: rising pin edges count, 1: falling pin edges count |
| use_ps | input | 1 | 1: prescaler assigned to this timer, count on `ps_tick` |
| ps_tick | input | 1 | Output of the shared prescaler |
| sleep | input | 1 | Core in sleep; counting frozen |
| wr_en | input | 1 | CPU write strobe for the count |
| wr_data | input | 8 | Value loaded on a write |
| flag_clr | input | 1 | Software clear of the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| cnt | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| ps_clr | output | 1 | One-cycle prescaler clear after a write |
| pre_src | output | 1 | Raw selected source toward the prescaler |

## Verification
The hardest cases to reach need the stimulus locked to the quarter-phase strobes. One is a pin pulse one clock wide that passes between two sampling strobes. The other is a flag clear that lands on the very edge where the count wraps. The bench keeps its own copy of the phase counter that produces the strobes. It starts every scenario at the first-quarter edge and counts edges from there. This lets it place the narrow pulse so the synchronizer delivers it between the second-quarter and fourth-quarter samples. It also lets it raise the clear on the third fourth-quarter edge after loading 8'hFF.

// File: rtl/timer8_pkg.sv
// Package: shared constants for the synchronized timer/counter.
// Assumes one instruction cycle is four clocks with one-hot phase strobes.
package timer8_pkg;
    localparam int unsigned CNT_W       = 8;  // count width
    localparam int unsigned HOLD_CYC    = 2;  // instruction cycles frozen after a write
    localparam int unsigned SYNC_STAGES = 2;  // flops on the raw pin
endpackage

// File: rtl/t8_pin_sync.sv
// Module: t8_pin_sync
// Brings the asynchronous count pin into the clock domain through a flop
// chain and applies the edge polarity by XOR. Assumes STAGES >= 2.
module t8_pin_sync #(
    parameter int unsigned STAGES = timer8_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic invert,
    output logic lvl
);
    logic [STAGES-1:0] sr_q;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], pin_raw};
    end

    // Polarity select: a falling pin edge becomes a rising level edge.
    assign lvl = sr_q[STAGES-1] ^ invert;
endmodule

// File: rtl/t8_tick_sampler.sv
// Module: t8_tick_sampler
// Samples a tick level on the Q2 and Q4 strobes and turns a low-to-high
// change seen at either sample into a one-clock increment request on Q4.
// Assumes ph_q2 and ph_q4 are never high together.
module t8_tick_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_q2,
    input  logic ph_q4,
    input  logic tick,
    output logic inc_q4
);
    logic samp_q;   // last sampled level
    logic pend_q;   // rise seen at Q2, waiting for Q4

    logic rise_now;
    assign rise_now = tick & ~samp_q;

    // Update the sample on Q2/Q4 and remember a rise seen at Q2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (ph_q2) begin
            samp_q <= tick;
            if (rise_now) pend_q <= 1'b1;
        end else if (ph_q4) begin
            samp_q <= tick;
            pend_q <= 1'b0;
        end
    end

    // Increment request is valid only at the Q4 edge.
    assign inc_q4 = ph_q4 & (pend_q | rise_now);

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q4 |=> !pend_q);                                               // R6
endmodule

// File: rtl/t8_count_core.sv
// Module: t8_count_core
// Holds the count, the post-write freeze and the sticky overflow flag.
// Assumes inc_req is only meaningful while ph_q4 is high.
module t8_count_core #(
    parameter int unsigned W    = timer8_pkg::CNT_W,
    parameter int unsigned HOLD = timer8_pkg::HOLD_CYC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ph_q4,
    input  logic         inc_req,
    input  logic         sleep,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         flag_clr,
    output logic [W-1:0] cnt,
    output logic         flag
);
    localparam int unsigned HW = $clog2(HOLD + 1);

    logic [W-1:0]  cnt_q;
    logic [HW-1:0] hold_q;
    logic          flag_q;
    logic          do_inc;
    logic          wrap;

    assign do_inc = ph_q4 & inc_req & ~sleep & (hold_q == '0) & ~wr_en;
    assign wrap   = do_inc & (cnt_q == {W{1'b1}});

    // Count register and post-write freeze counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (wr_en) begin
            cnt_q  <= wr_data;
            hold_q <= HW'(HOLD);
        end else if (ph_q4 && hold_q != '0) begin
            hold_q <= hold_q - HW'(1);
        end else if (do_inc) begin
            cnt_q  <= cnt_q + W'(1);
        end
    end

    // Sticky overflow flag; a wrap beats a same-edge clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= wrap | (flag_q & ~flag_clr);
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1))); // R1
    AST_Q4_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ph_q4) |=> $stable(cnt_q));                           // R1
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q != '0 && !wr_en) |=> $stable(cnt_q));                     // R3
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_data)));                             // R3
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == {W{1'b1}} && !wr_en) |=> (cnt_q == {W{1'b1}} || flag_q)); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);                                // R4
    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !wr_en) |=> $stable(cnt_q));                            // R7
    AST_SLEEP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !flag_q) |=> !flag_q);                                  // R7
endmodule

// File: rtl/sync_timer8.sv
// Module: sync_timer8 (top)
// Eight-bit timer/counter: selects instruction-cycle, pin or prescaler tick,
// samples it on Q2/Q4, counts on Q4, freezes after writes, flags wrap.
// Assumes ph_q2/ph_q4 come from a divide-by-four of clk, one clock wide each.
module sync_timer8 #(
    parameter int unsigned W = timer8_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ph_q2,
    input  logic         ph_q4,
    input  logic         ext_pin,
    input  logic         src_ext,
    input  logic         edge_fall,
    input  logic         use_ps,
    input  logic         ps_tick,
    input  logic         sleep,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         flag_clr,
    input  logic         irq_en,
    output logic [W-1:0] cnt,
    output logic         ovf_flag,
    output logic         irq,
    output logic         ps_clr,
    output logic         pre_src
);
    logic pin_lvl;
    logic samp_tick;
    logic samp_inc;
    logic inc_req;
    logic ps_clr_q;

    t8_pin_sync #(.STAGES(timer8_pkg::SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_raw(ext_pin),
        .invert(edge_fall), .lvl(pin_lvl)
    );

    // Sampled tick: prescaler output when assigned, else the conditioned pin.
    assign samp_tick = use_ps ? ps_tick : pin_lvl;

    t8_tick_sampler u_samp (
        .clk(clk), .rst_n(rst_n), .ph_q2(ph_q2), .ph_q4(ph_q4),
        .tick(samp_tick), .inc_q4(samp_inc)
    );

    // Timer mode without prescaler counts every Q4 directly.
    assign inc_req = (!use_ps && !src_ext) ? 1'b1 : samp_inc;

    t8_count_core #(.W(W), .HOLD(timer8_pkg::HOLD_CYC)) u_core (
        .clk(clk), .rst_n(rst_n), .ph_q4(ph_q4), .inc_req(inc_req),
        .sleep(sleep), .wr_en(wr_en), .wr_data(wr_data),
        .flag_clr(flag_clr), .cnt(cnt), .flag(ovf_flag)
    );

    // One-cycle prescaler clear following a write while assigned.
    always_ff @(posedge clk) begin
        if (!rst_n) ps_clr_q <= 1'b0;
        else        ps_clr_q <= wr_en & use_ps;
    end

    assign ps_clr  = ps_clr_q;
    assign irq     = ovf_flag & irq_en;
    assign pre_src = src_ext ? (ext_pin ^ edge_fall) : ph_q4;

    AST_PS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && use_ps) |=> ps_clr);                                    // R8
    AST_PS_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_clr && !wr_en) |=> !ps_clr);                                  // R8
endmodule

// File: tb/tb_sync_timer8.sv
module tb_sync_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ph;
    logic       ph_q2, ph_q4;
    logic       ext_pin = 0, src_ext = 0, edge_fall = 0, use_ps = 0, ps_tick = 0;
    logic       sleep = 0, wr_en = 0, flag_clr = 0, irq_en = 1;
    logic [7:0] wr_data = '0;
    logic [7:0] cnt;
    logic       ovf_flag, irq, ps_clr, pre_src;
    int         n_chk = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    // Quarter-phase generator: divide-by-four of clk.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 2'd0;
        else        ph <= ph + 2'd1;
    end
    assign ph_q2 = (ph == 2'd1);
    assign ph_q4 = (ph == 2'd3);

    sync_timer8 dut (
        .clk(clk), .rst_n(rst_n), .ph_q2(ph_q2), .ph_q4(ph_q4),
        .ext_pin(ext_pin), .src_ext(src_ext), .edge_fall(edge_fall),
        .use_ps(use_ps), .ps_tick(ps_tick), .sleep(sleep), .wr_en(wr_en),
        .wr_data(wr_data), .flag_clr(flag_clr), .irq_en(irq_en),
        .cnt(cnt), .ovf_flag(ovf_flag), .irq(irq), .ps_clr(ps_clr),
        .pre_src(pre_src)
    );

    // Vector: {load value, instruction cycles waited, expected count, expected flag}
    localparam logic [24:0] VECS [8] = '{
        {8'h40, 8'd1, 8'h40, 1'b0},
        {8'h40, 8'd2, 8'h40, 1'b0},
        {8'h40, 8'd3, 8'h41, 1'b0},
        {8'h00, 8'd7, 8'h05, 1'b0},
        {8'hFD, 8'd3, 8'hFE, 1'b0},
        {8'hFE, 8'd4, 8'h00, 1'b1},
        {8'hFF, 8'd3, 8'h00, 1'b1},
        {8'hF0, 8'd20, 8'h02, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Park at a negedge whose following posedge is a Q1 edge.
    task automatic to_q1;
        @(negedge clk);
        while (ph != 2'd0) @(negedge clk);
    endtask

    // Write at the next Q1 edge (also clears the flag); returns at the negedge after.
    task automatic do_write(input logic [7:0] v);
        to_q1();
        wr_data = v; wr_en = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 cnt", cnt, 8'h00);
        chk("R10 flag", ovf_flag, 0);
        chk("R10 ps_clr", ps_clr, 0);
        rst_n = 1'b1;

        // R1 R3 R4 R5: table walk in timer mode
        for (int i = 0; i < 8; i++) begin
            do_write(VECS[i][24:17]);
            wait_n(4 * int'(VECS[i][16:9]) - 1);
            chk("R1/R3 count", cnt, VECS[i][8:1]);
            chk("R4 flag", ovf_flag, VECS[i][0]);
            chk("R5 irq", irq, VECS[i][0]);
        end

        // R7: sleep freezes count and flag
        sleep = 1'b1;
        do_write(8'hFF);
        wait_n(40);
        chk("R7 cnt frozen", cnt, 8'hFF);
        chk("R7 no flag", ovf_flag, 0);
        to_q1(); sleep = 1'b0;
        wait_n(4);
        chk("R7 resume wrap", cnt, 8'h00);
        chk("R4 wrap sets", ovf_flag, 1);
        wait_n(8);
        chk("R4 sticky", ovf_flag, 1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R4 cleared", ovf_flag, 0);

        // R4 R5: clear on the wrap edge loses; masked irq
        irq_en = 1'b0;
        do_write(8'hFF);
        wait_n(10);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R4 same-edge cnt", cnt, 8'h00);
        chk("R4 same-edge flag", ovf_flag, 1);
        chk("R5 masked", irq, 0);
        irq_en = 1'b1; #1;
        chk("R5 unmasked", irq, 1);

        // R2: edge polarity in counter mode
        src_ext = 1'b1;
        do_write(8'h10);
        wait_n(12);
        ext_pin = 1'b1; wait_n(12);
        chk("R2 rising counts", cnt, 8'h11);
        edge_fall = 1'b1; wait_n(12);
        chk("R2 select change no count", cnt, 8'h11);
        ext_pin = 1'b0; wait_n(12);
        chk("R2 falling counts", cnt, 8'h12);
        ext_pin = 1'b1; wait_n(12);
        chk("R2 rising ignored", cnt, 8'h12);
        ext_pin = 1'b0; wait_n(12);
        chk("R2 falling again", cnt, 8'h13);
        edge_fall = 1'b0; wait_n(12);
        chk("R2 back to rising no count", cnt, 8'h13);

        // R6: one-clock pulse between strobes lost, two-clock pulse counted
        to_q1(); ext_pin = 1'b1; @(negedge clk); ext_pin = 1'b0;
        wait_n(12);
        chk("R6 narrow missed", cnt, 8'h13);
        to_q1(); ext_pin = 1'b1; wait_n(2); ext_pin = 1'b0;
        wait_n(12);
        chk("R6 two-clock seen", cnt, 8'h14);

        // R8 R9: prescaler path
        use_ps = 1'b1; src_ext = 1'b0;
        to_q1(); wr_data = 8'h20; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        chk("R8 clr pulse", ps_clr, 1);
        @(negedge clk);
        chk("R8 clr one cycle", ps_clr, 0);
        wait_n(12);
        chk("R9 no tick no count", cnt, 8'h20);
        for (int k = 0; k < 2; k++) begin
            ps_tick = 1'b1; wait_n(8); ps_tick = 1'b0; wait_n(8);
        end
        chk("R9 ps ticks", cnt, 8'h22);
        while (ph != 2'd3) @(negedge clk);
        chk("R9 pre_src internal q4", pre_src, 1);
        @(negedge clk);
        chk("R9 pre_src internal other", pre_src, 0);
        src_ext = 1'b1; edge_fall = 1'b1; ext_pin = 1'b1; #1;
        chk("R9 pre_src pin", pre_src, 0);
        use_ps = 1'b0; edge_fall = 1'b0; ext_pin = 1'b0; src_ext = 1'b0;
        do_write(8'h30);
        chk("R8 no clr unassigned", ps_clr, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule